// File: doc/BRIEF.md
# DRAM Refresh and Initialization Controller

This block keeps a bank of asynchronous DRAM alive. After reset it waits out the power-up pause. It then runs a short series of CAS-before-RAS (CBR) refresh cycles and raises a flag that tells the rest of the memory subsystem the array is usable. From then on it issues one CBR refresh per refresh interval. The interval is derived from the clock frequency, the number of rows per refresh window and the window length. Up to a fixed number of late refreshes are remembered and paid back back-to-back.

The controller shares the strobes with an access sequencer. When it needs the bus it raises a request and waits for a grant, and only then drives RAS and CAS. It keeps the request up until the RAS precharge after its last cycle has elapsed. On command it parks the DRAM in self refresh, where it holds a CBR cycle with RAS low for at least the minimum self-refresh time. On the exit command it restores RAS high for the exit recovery time. It then runs a full window's worth of back-to-back CBR cycles before the periodic interval starts again.

Top module: `dram_rfc_ctrl`

## Requirements
- R1: While reset is held and right after it, ras_n, cas_n and we_n are high, bus_req and init_done are low, and busy is high.
- R2: After reset the controller does not raise bus_req for INIT_CYC = ceil(INIT_WAIT_NS x CLK_MHZ / 1000) cycles. An sr_enter pulse before init_done is ignored, so the first strobe cycle is an ordinary CBR cycle.
- R3: Exactly INIT_REFRESHES CBR cycles are issued before init_done rises. init_done rises in the same cycle that bus_req falls, and it never falls again until reset.
- R4: ras_n and cas_n are low only while bus_req is high and bus_gnt has been given. While the controller waits for a grant, both strobes stay high.
- R5: In every CBR cycle, cas_n is low for exactly LEAD_CYC cycles (ceil of CAS_LEAD_NS) before ras_n falls. cas_n stays low for the whole RAS-low time, and ras_n is low for exactly RAS_CYC cycles (ceil of RAS_LOW_NS). we_n is high at all times.
- R6: Between two RAS-low pulses, and between the last RAS rise and the fall of bus_req, ras_n stays high for at least PRE_CYC cycles (ceil of PRECHARGE_NS).
- R7: With init_done high and an immediate grant, successive periodic refreshes start exactly INTERVAL = floor(REFRESH_WINDOW_NS x CLK_MHZ / 1000 / REFRESH_ROWS) cycles apart.
- R8: Interval expiries that occur while a refresh waits for the grant are counted, up to MAX_BACKLOG. Once granted, the pending refreshes run back-to-back: one request cycle plus LEAD_CYC between the end of one precharge and the next RAS fall, with no release of bus_req.
- R9: An sr_enter seen while idle starts a request. After the grant, cas_n falls LEAD_CYC cycles before ras_n. Both stay low for at least SELF_CYC cycles (ceil of SELF_MIN_NS), and busy stays high the whole time.
- R10: An sr_exit that arrives before SELF_CYC cycles have elapsed is remembered and acted on when the minimum time expires. On exit, ras_n stays high for at least EXIT_CYC cycles (ceil of SELF_EXIT_NS). Exactly REFRESH_ROWS CBR cycles then follow before bus_req falls. An sr_exit outside self refresh has no effect.
- R11: busy is low exactly when the controller is idle after initialization, so it is low whenever bus_req is low and init_done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_gnt | input | 1 | Grant from the access sequencer; held while bus_req is high |
| sr_enter | input | 1 | Command to enter self refresh (sampled when idle) |
| sr_exit | input | 1 | Command to leave self refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| bus_req | output | 1 | Request for the DRAM strobes |
| init_done | output | 1 | Power-up sequence complete |
| busy | output | 1 | Controller is not idle |

## Verification
A wrong sequencer state shows within one strobe pulse. A bad lead or hold timer shifts the CAS-to-RAS spacing or the RAS-low width at the very next pulse, and every pulse is scored against an expected queue of CBR and self-refresh items. A wrong pending count or burst counter cannot be seen until a request is finally granted. It then shows as a wrong number of back-to-back pulses before bus_req falls, which the bench counts after a long grant stall and after each self-refresh exit. A lost or stray self-refresh command shows as a mis-typed pulse, or as a request that should not appear in the quiet window after an ignored command.

// File: rtl/dram_rfc_pkg.sv
package dram_rfc_pkg;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_REQ,
        ST_LEAD,
        ST_RAS,
        ST_PRE,
        ST_SELF,
        ST_EXIT
    } rfc_state_e;

    // nanoseconds to clock cycles, rounded up
    function automatic longint ns2cyc(longint ns, longint mhz);
        return (ns * mhz + 64'd999) / 64'd1000;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfc_tick.sv
module rfc_tick #(
    parameter int INTERVAL = 1953
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int IW = $clog2(INTERVAL + 1);

    typedef struct packed {
        logic [IW-1:0] cnt;
    } tick_s;

    tick_s q, d;

    always_comb begin
        d    = q;
        tick = 1'b0;
        if (!en) begin
            d.cnt = '0;
        end else if (q.cnt == IW'(INTERVAL - 1)) begin
            d.cnt = '0;
            tick  = 1'b1;
        end else begin
            d.cnt = q.cnt + IW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    p_tick_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= IW'(INTERVAL - 1));

endmodule

// File: rtl/rfc_backlog.sv
module rfc_backlog #(
    parameter int MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    input  logic clr,
    output logic work
);
    localparam int PW = $clog2(MAX + 1);

    typedef struct packed {
        logic [PW-1:0] pend;
    } blog_s;

    blog_s q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d.pend = '0;
        end else if (inc && !dec) begin
            if (q.pend != PW'(MAX)) d.pend = q.pend + PW'(1);
        end else if (dec && !inc) begin
            if (q.pend != '0) d.pend = q.pend - PW'(1);
        end
        work = (q.pend != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    p_backlog_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.pend <= PW'(MAX));

    p_backlog_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pend == PW'(MAX) && inc && !dec && !clr) |=> (q.pend == PW'(MAX)));

endmodule

// File: rtl/rfc_seq.sv
module rfc_seq
    import dram_rfc_pkg::*;
#(
    parameter int INIT_CYC       = 25000,
    parameter int LEAD_CYC       = 2,
    parameter int RAS_CYC        = 8,
    parameter int PRE_CYC        = 5,
    parameter int SELF_CYC       = 12500,
    parameter int EXIT_CYC       = 14,
    parameter int INIT_REFRESHES = 8,
    parameter int REFRESH_ROWS   = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_gnt,
    input  logic sr_enter,
    input  logic sr_exit,
    input  logic work,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic bus_req,
    output logic init_done,
    output logic busy,
    output logic tick_en,
    output logic done,
    output logic clr
);
    localparam int MAXT = max2(max2(INIT_CYC, SELF_CYC),
                               max2(max2(LEAD_CYC, RAS_CYC), max2(PRE_CYC, EXIT_CYC)));
    localparam int TW   = $clog2(MAXT + 1);
    localparam int BW   = $clog2(max2(REFRESH_ROWS, INIT_REFRESHES) + 1);

    typedef struct packed {
        rfc_state_e      st;
        logic [TW-1:0]   tmr;
        logic [BW-1:0]   burst;
        logic            self_m;
        logic            exit_seen;
        logic            init_done;
    } seq_s;

    seq_s q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        clr  = 1'b0;
        unique case (q.st)
            ST_INIT: begin
                if (q.tmr == '0) begin
                    d.st    = ST_REQ;
                    d.burst = BW'(INIT_REFRESHES);
                end else begin
                    d.tmr = q.tmr - TW'(1);
                end
            end
            ST_IDLE: begin
                if (sr_enter) begin
                    d.st        = ST_REQ;
                    d.self_m    = 1'b1;
                    d.exit_seen = 1'b0;
                    clr         = 1'b1;
                end else if (work) begin
                    d.st = ST_REQ;
                end
            end
            ST_REQ: begin
                if (bus_gnt) begin
                    d.st  = ST_LEAD;
                    d.tmr = TW'(LEAD_CYC - 1);
                end
            end
            ST_LEAD: begin
                if (q.tmr != '0) begin
                    d.tmr = q.tmr - TW'(1);
                end else if (q.self_m) begin
                    d.st  = ST_SELF;
                    d.tmr = TW'(SELF_CYC - 1);
                end else begin
                    d.st  = ST_RAS;
                    d.tmr = TW'(RAS_CYC - 1);
                end
            end
            ST_RAS: begin
                if (q.tmr != '0) begin
                    d.tmr = q.tmr - TW'(1);
                end else begin
                    d.st  = ST_PRE;
                    d.tmr = TW'(PRE_CYC - 1);
                    if (q.burst != '0) d.burst = q.burst - BW'(1);
                    else               done    = 1'b1;
                end
            end
            ST_PRE: begin
                if (q.tmr != '0) begin
                    d.tmr = q.tmr - TW'(1);
                end else if (q.burst != '0 || work) begin
                    d.st = ST_REQ;
                end else begin
                    d.st        = ST_IDLE;
                    d.init_done = 1'b1;
                end
            end
            ST_SELF: begin
                if (sr_exit) d.exit_seen = 1'b1;
                if (q.tmr != '0) begin
                    d.tmr = q.tmr - TW'(1);
                end else if (q.exit_seen || sr_exit) begin
                    d.st     = ST_EXIT;
                    d.tmr    = TW'(EXIT_CYC - 1);
                    d.self_m = 1'b0;
                    d.burst  = BW'(REFRESH_ROWS);
                end
            end
            ST_EXIT: begin
                if (q.tmr != '0) d.tmr = q.tmr - TW'(1);
                else             d.st  = ST_REQ;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q           <= '0;
            q.st        <= ST_INIT;
            q.tmr       <= TW'(INIT_CYC - 1);
        end else begin
            q <= d;
        end
    end

    assign cas_n     = !(q.st == ST_LEAD || q.st == ST_RAS || q.st == ST_SELF);
    assign ras_n     = !(q.st == ST_RAS || q.st == ST_SELF);
    assign we_n      = 1'b1;
    assign bus_req   = !(q.st == ST_INIT || q.st == ST_IDLE);
    assign busy      = (q.st != ST_IDLE);
    assign init_done = q.init_done;
    assign tick_en   = q.init_done && (q.burst == '0) && !q.self_m;

    p_cbr_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n));

    p_strobe_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n) |-> bus_req);

    p_init_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(init_done));

    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |-> (init_done && !bus_req));

endmodule

// File: rtl/dram_rfc_ctrl.sv
module dram_rfc_ctrl
    import dram_rfc_pkg::*;
#(
    parameter int CLK_MHZ           = 125,
    parameter int INIT_WAIT_NS      = 200000,
    parameter int REFRESH_ROWS      = 4096,
    parameter int REFRESH_WINDOW_NS = 64000000,
    parameter int INIT_REFRESHES    = 8,
    parameter int MAX_BACKLOG       = 8,
    parameter int CAS_LEAD_NS       = 10,
    parameter int RAS_LOW_NS        = 60,
    parameter int PRECHARGE_NS      = 40,
    parameter int SELF_MIN_NS       = 100000,
    parameter int SELF_EXIT_NS      = 110
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_gnt,
    input  logic sr_enter,
    input  logic sr_exit,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic bus_req,
    output logic init_done,
    output logic busy
);
    localparam int INIT_CYC = int'(ns2cyc(longint'(INIT_WAIT_NS), longint'(CLK_MHZ)));
    localparam int LEAD_CYC = int'(ns2cyc(longint'(CAS_LEAD_NS),  longint'(CLK_MHZ)));
    localparam int RAS_CYC  = int'(ns2cyc(longint'(RAS_LOW_NS),   longint'(CLK_MHZ)));
    localparam int PRE_CYC  = int'(ns2cyc(longint'(PRECHARGE_NS), longint'(CLK_MHZ)));
    localparam int SELF_CYC = int'(ns2cyc(longint'(SELF_MIN_NS),  longint'(CLK_MHZ)));
    localparam int EXIT_CYC = int'(ns2cyc(longint'(SELF_EXIT_NS), longint'(CLK_MHZ)));
    localparam int INTERVAL = int'((longint'(REFRESH_WINDOW_NS) * longint'(CLK_MHZ) / 64'd1000)
                                   / longint'(REFRESH_ROWS));

    logic tick_en, tick, work, done, clr;

    rfc_tick #(.INTERVAL(INTERVAL)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tick_en),
        .tick  (tick)
    );

    rfc_backlog #(.MAX(MAX_BACKLOG)) u_backlog (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (tick),
        .dec   (done),
        .clr   (clr),
        .work  (work)
    );

    rfc_seq #(
        .INIT_CYC       (INIT_CYC),
        .LEAD_CYC       (LEAD_CYC),
        .RAS_CYC        (RAS_CYC),
        .PRE_CYC        (PRE_CYC),
        .SELF_CYC       (SELF_CYC),
        .EXIT_CYC       (EXIT_CYC),
        .INIT_REFRESHES (INIT_REFRESHES),
        .REFRESH_ROWS   (REFRESH_ROWS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_gnt   (bus_gnt),
        .sr_enter  (sr_enter),
        .sr_exit   (sr_exit),
        .work      (work),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .bus_req   (bus_req),
        .init_done (init_done),
        .busy      (busy),
        .tick_en   (tick_en),
        .done      (done),
        .clr       (clr)
    );

    // pulse-width watch counters for the assertions below
    localparam int LW = $clog2(RAS_CYC + 1);
    localparam int HW = $clog2(PRE_CYC + 1);
    logic [LW-1:0] low_cnt_q;
    logic [HW-1:0] high_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt_q  <= '0;
            high_cnt_q <= '0;
        end else begin
            if (ras_n)                       low_cnt_q <= '0;
            else if (low_cnt_q != LW'(RAS_CYC)) low_cnt_q <= low_cnt_q + LW'(1);
            if (!ras_n)                      high_cnt_q <= '0;
            else if (high_cnt_q != HW'(PRE_CYC)) high_cnt_q <= high_cnt_q + HW'(1);
        end
    end

    p_ras_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (low_cnt_q == LW'(RAS_CYC)));

    p_release_precharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_req) && init_done) |-> (high_cnt_q == HW'(PRE_CYC)));

    p_precharge_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (high_cnt_q == HW'(PRE_CYC)));

endmodule

// File: tb/dram_rfc_ctrl_test.sv
module dram_rfc_ctrl_test;
    localparam int INIT_CYC = 250;
    localparam int LEAD     = 2;
    localparam int RASC     = 8;
    localparam int PRE      = 5;
    localparam int SELFC    = 200;
    localparam int EXITC    = 14;
    localparam int INTERVAL = 100;
    localparam int ROWS     = 16;
    localparam int NINIT    = 8;
    localparam int MAXB     = 8;

    logic clk = 1'b0, rst_n = 1'b0, bus_gnt = 1'b0, sr_enter = 1'b0, sr_exit = 1'b0;
    logic ras_n, cas_n, we_n, bus_req, init_done, busy;

    dram_rfc_ctrl #(
        .CLK_MHZ(125), .INIT_WAIT_NS(2000), .REFRESH_ROWS(ROWS),
        .REFRESH_WINDOW_NS(12800), .INIT_REFRESHES(NINIT), .MAX_BACKLOG(MAXB),
        .CAS_LEAD_NS(10), .RAS_LOW_NS(60), .PRECHARGE_NS(40),
        .SELF_MIN_NS(1600), .SELF_EXIT_NS(110)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .sr_enter(sr_enter), .sr_exit(sr_exit),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .bus_req(bus_req),
        .init_done(init_done), .busy(busy)
    );

    always #4 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // sequencer model: grant after gnt_delay cycles, drop with the request
    int gnt_delay = 0, gcnt = 0;
    always @(negedge clk) begin
        if (!bus_req) begin
            bus_gnt <= 1'b0;
            gcnt    <= 0;
        end else if (!bus_gnt) begin
            if (gcnt >= gnt_delay) bus_gnt <= 1'b1;
            else                   gcnt    <= gcnt + 1;
        end
    end

    // scoreboard
    typedef enum {K_CBR, K_SELF} kind_e;
    kind_e expq[$];

    bit ras_p = 1'b1, req_p = 1'b0, bad_cas = 1'b0;
    int cas_lead = 0, low_len = 0, rise_cyc = 0, last_fall = 0, spacing = 0;
    int pulses = 0, grant_viol = 0, we_viol = 0, self_len = 0, gap = 0;
    kind_e last_kind = K_CBR;

    always @(negedge clk) begin
        if (rst_n) begin
            if ((!ras_n || !cas_n) && !bus_gnt) grant_viol++;
            if (!we_n) we_viol++;
            if (ras_p && !ras_n) begin
                gap       = cyc - rise_cyc;
                spacing   = cyc - last_fall;
                last_fall = cyc;
                if (pulses > 0) begin
                    chk(gap >= PRE, "R6", "ras high between pulses", gap, PRE);
                    if (last_kind == K_SELF)
                        chk(gap >= EXITC, "R10", "ras high after self exit", gap, EXITC);
                end
                low_len = 0;
                bad_cas = 1'b0;
            end
            if (!ras_n) begin
                low_len++;
                if (cas_n) bad_cas = 1'b1;
            end
            if (!ras_p && ras_n) begin
                kind_e k;
                k = (expq.size() > 0) ? expq.pop_front() : K_CBR;
                pulses++;
                rise_cyc  = cyc;
                last_kind = k;
                chk(!bad_cas, "R5", "cas low through ras low", bad_cas, 0);
                if (k == K_CBR) begin
                    chk(low_len == RASC, "R5", "cbr ras low width", low_len, RASC);
                    chk(cas_lead == LEAD, "R5", "cas lead before ras", cas_lead, LEAD);
                end else begin
                    self_len = low_len;
                    chk(low_len >= SELFC, "R9", "self refresh ras low", low_len, SELFC);
                end
            end
            if (cas_n) cas_lead = 0;
            else if (ras_n) cas_lead++;
            if (req_p && !bus_req && init_done)
                chk(cyc - rise_cyc >= PRE, "R6", "precharge before release", cyc - rise_cyc, PRE);
            ras_p = ras_n;
            req_p = bus_req;
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        int cnt, p0, first, burst;
        repeat (5) @(negedge clk);
        // R1 reset values
        chk(ras_n && cas_n && we_n, "R1", "strobes high in reset", {ras_n, cas_n, we_n}, 7);
        chk(!bus_req && !init_done && busy, "R1", "flags in reset",
            {bus_req, init_done, busy}, 1);
        for (int i = 0; i < NINIT; i++) expq.push_back(K_CBR);
        rst_n = 1'b1;
        cnt = 0;
        // R2 ignored early self refresh command
        @(negedge clk); cnt++; sr_enter = 1'b1;
        @(negedge clk); cnt++; sr_enter = 1'b0;
        while (!bus_req) begin @(negedge clk); cnt++; end
        chk(cnt >= INIT_CYC && cnt <= INIT_CYC + 1, "R2", "power-up wait", cnt, INIT_CYC);

        while (!init_done) @(negedge clk);
        chk(pulses == NINIT, "R3", "refreshes before init_done", pulses, NINIT);
        chk(!bus_req, "R3", "request dropped with init_done", bus_req, 0);
        chk(!busy, "R11", "idle after init", busy, 0);

        // R7 periodic spacing
        while (pulses < NINIT + 2) @(negedge clk);
        chk(spacing == INTERVAL, "R7", "refresh spacing", spacing, INTERVAL);
        while (pulses < NINIT + 3) @(negedge clk);
        chk(spacing == INTERVAL, "R7", "refresh spacing again", spacing, INTERVAL);

        // R8 backlog during a long grant stall
        while (bus_req) @(negedge clk);
        gnt_delay = 2000;
        while (!bus_req) @(negedge clk);
        p0 = pulses;
        repeat (20) @(negedge clk);
        chk(ras_n && cas_n, "R4", "strobes high while waiting", {ras_n, cas_n}, 3);
        while (ras_n) @(negedge clk);
        first = cyc;
        while (bus_req) @(negedge clk);
        burst = pulses - p0;
        chk(burst >= MAXB && burst <= MAXB + 2, "R8", "backlog burst length", burst, MAXB);
        chk(last_fall - first == (burst - 1) * (RASC + PRE + 1 + LEAD), "R8",
            "back-to-back spacing", last_fall - first, (burst - 1) * (RASC + PRE + 1 + LEAD));
        gnt_delay = 0;
        chk(!busy, "R11", "busy low after release", busy, 0);

        // R9 and R10: self refresh with early exit command
        while (bus_req) @(negedge clk);
        expq.push_back(K_SELF);
        sr_enter = 1'b1;
        p0 = pulses;
        @(negedge clk); sr_enter = 1'b0;
        while (ras_n) @(negedge clk);
        repeat (50) @(negedge clk);
        chk(busy && !cas_n && !ras_n, "R9", "held in self refresh", {busy, cas_n, ras_n}, 4);
        sr_exit = 1'b1;
        @(negedge clk); sr_exit = 1'b0;
        while (bus_req) @(negedge clk);
        chk(self_len == SELFC, "R10", "early exit deferred to minimum", self_len, SELFC);
        chk(pulses - p0 - 1 == ROWS, "R10", "refresh burst after exit", pulses - p0 - 1, ROWS);

        // R10 stray exit command is ignored
        sr_exit = 1'b1;
        @(negedge clk); sr_exit = 1'b0;
        p0 = pulses;
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (bus_req || !ras_n) cnt++;
        end
        chk(cnt == 0 && pulses == p0, "R10", "stray exit ignored", cnt, 0);

        // R9 self refresh with late exit
        while (bus_req) @(negedge clk);
        expq.push_back(K_SELF);
        sr_enter = 1'b1;
        @(negedge clk); sr_enter = 1'b0;
        while (ras_n) @(negedge clk);
        repeat (300) @(negedge clk);
        sr_exit = 1'b1;
        @(negedge clk); sr_exit = 1'b0;
        while (bus_req) @(negedge clk);
        chk(self_len >= 300 && self_len <= 303, "R9", "self refresh follows exit", self_len, 301);

        chk(grant_viol == 0, "R4", "strobe without grant", grant_viol, 0);
        chk(we_viol == 0, "R5", "we_n low", we_viol, 0);
        chk(expq.size() == 0, "R3", "expected pulses left", expq.size(), 0);
        finish_run();
    end
endmodule